// File: doc/BRIEF.md
# Serial Port Status and Request Core

This block is the flag and control heart of an asynchronous serial port. Software reaches it through a small word-addressed register bus with a status word, a data word and two control words. It keeps one holding byte for the transmit path and one buffer byte for the receive path, and it tracks four status flags: transmit-buffer-empty, transmission-complete, receive-buffer-full and overrun. From those flags it drives one interrupt line and two DMA request lines, one for each direction.

The serialiser and deserialiser sit outside. The transmit shifter sees a byte offered on `tx_data`/`tx_valid`, confirms it took the byte with `tx_take`, and pulses `tx_stop_done` when a stop bit has left the line. The receive deserialiser pulses `rx_valid` with a finished byte on `rx_data`. Bus reads have no wait states. `bus_rdata` follows the address combinationally while `bus_rd` is high, and read side effects take place at the clock edge.

Top module: `usart_stat_core`

## Requirements
- R1: After reset the status word reads 0xC0: transmit-empty (bit 7) and transmit-complete (bit 6) are 1, and receive-full (bit 5) and overrun (bit 3) are 0. Both control words read 0, and `irq`, `dma_tx_req`, `dma_rx_req` and `tx_valid` are low.
- R2: A write to the data word (index 1) while the port is enabled (control bit 0) and the transmitter is on (control bit 1) loads the byte and clears transmit-empty. `tx_valid` then offers that byte on `tx_data`. A data write while either bit is 0 is ignored.
- R3: A `tx_take` pulse while `tx_valid` is high sets transmit-empty again and drops `tx_valid`.
- R4: A `tx_stop_done` pulse sets transmit-complete only if transmit-empty is 1 and no data write happens in the same cycle. Otherwise the flag keeps its value.
- R5: Writing the status word (index 0) with bit 6 at 0 clears transmit-complete. Writing bit 6 as 1 leaves it unchanged. A set event in the same cycle wins over the clear.
- R6: An `rx_valid` pulse while the port is enabled and the receiver is on (control bit 2) stores the byte and sets receive-full, provided receive-full is 0 or the data word is being read in that cycle. A read of the data word returns the stored byte and clears receive-full.
- R7: An accepted `rx_valid` while receive-full is 1 and the data word is not being read sets overrun and discards the new byte.
- R8: Any read of the data word clears overrun.
- R9: `irq` is high when transmit-complete is set and its enable (control bit 3) is set, or when overrun is set and the error enable (DMA-control word index 3, bit 0) is set.
- R10: `dma_tx_req` is high while DMA-control bit 1, transmit-empty, port enable and transmitter-on are all set. `dma_rx_req` is high while DMA-control bit 2, receive-full, port enable and receiver-on are all set.
- R11: While the port enable is 0, `tx_valid` stays low and `rx_valid` pulses are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | ADDR_W (4) | Byte address; bits [ADDR_W-1:2] pick the word |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe; read side effects act at the edge |
| bus_wdata | input | BUS_W (32) | Write data |
| bus_rdata | output | BUS_W (32) | Read data, zero when `bus_rd` is low |
| tx_data | output | DATA_W (8) | Holding byte offered to the shifter |
| tx_valid | output | 1 | Holding byte waiting for the shifter |
| tx_take | input | 1 | Shifter took the offered byte |
| tx_stop_done | input | 1 | Shifter finished a stop bit |
| rx_data | input | DATA_W (8) | Byte from the deserialiser |
| rx_valid | input | 1 | Received byte finished this cycle |
| dma_tx_req | output | 1 | Transmit DMA request |
| dma_rx_req | output | 1 | Receive DMA request |
| irq | output | 1 | Interrupt request |

## Verification
The bench targets these corner cases:

- **Second byte before the first stop bit.** A byte is written while the previous one is still shifting out. A design that sets transmit-complete on every stop bit would report a finished line too early.
- **Stop bit coinciding with a data write.** If this is missed, the complete flag is raised over a byte that is still pending.
- **Overrun.** A second byte arrives before the first is read. A design that overwrote the buffer would return the newer byte, and one that forgot the overrun would leave the error interrupt silent.
- **Read racing a new byte.** A data read and a new byte land in the same cycle. This must hand over cleanly without an overrun.
- **Write-one to the status word.** A write of 1 to the complete bit must not clear it.
- **Partially enabled port.** With the transmitter off, or the whole port off, writes, received bytes and DMA requests must all stay inert.

// File: rtl/usart_core_pkg.sv
package usart_core_pkg;

   // word indices on the register bus
   localparam int unsigned REG_STAT = 0;
   localparam int unsigned REG_DATA = 1;
   localparam int unsigned REG_CTRL = 2;
   localparam int unsigned REG_DMAC = 3;

   // status word bit positions
   localparam int unsigned ST_TXE  = 7;
   localparam int unsigned ST_TC   = 6;
   localparam int unsigned ST_RXNE = 5;
   localparam int unsigned ST_ORE  = 3;

   // control word widths
   localparam int unsigned CTRL_W = 4;
   localparam int unsigned DMAC_W = 3;

   typedef struct packed {
      logic rx_dma;
      logic tx_dma;
      logic err_ie;
      logic tc_ie;
      logic rx_on;
      logic tx_on;
      logic enable;
   } cfg_t;

endpackage

// File: rtl/usart_cfg_regs.sv
module usart_cfg_regs
   import usart_core_pkg::*;
#(
   parameter int BUS_W = 32
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                wr_ctrl,
   input  logic                wr_dmac,
   input  logic [CTRL_W-1:0]   ctrl_wdata,
   input  logic [DMAC_W-1:0]   dmac_wdata,
   output cfg_t                cfg,
   output logic [BUS_W-1:0]    ctrl_word,
   output logic [BUS_W-1:0]    dmac_word
);

   logic [CTRL_W-1:0] ctrl_q;
   logic [DMAC_W-1:0] dmac_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= '0;
         dmac_q <= '0;
      end else begin
         if (wr_ctrl) ctrl_q <= ctrl_wdata;
         if (wr_dmac) dmac_q <= dmac_wdata;
      end
   end

   assign cfg.enable = ctrl_q[0];
   assign cfg.tx_on  = ctrl_q[1];
   assign cfg.rx_on  = ctrl_q[2];
   assign cfg.tc_ie  = ctrl_q[3];
   assign cfg.err_ie = dmac_q[0];
   assign cfg.tx_dma = dmac_q[1];
   assign cfg.rx_dma = dmac_q[2];

   assign ctrl_word = BUS_W'(ctrl_q);
   assign dmac_word = BUS_W'(dmac_q);

endmodule

// File: rtl/usart_tx_flags.sv
module usart_tx_flags #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tx_path_on,
   input  logic              dr_wr,
   input  logic [DATA_W-1:0] dr_wdata,
   input  logic              shf_take,
   input  logic              shf_stop_done,
   input  logic              tc_clr,
   output logic              txe,
   output logic              tc,
   output logic [DATA_W-1:0] hold,
   output logic              tx_valid
);

   logic take_ok;
   logic tc_set;

   assign tx_valid = tx_path_on & ~txe;
   assign take_ok  = shf_take & tx_valid;
   assign tc_set   = shf_stop_done & txe & ~dr_wr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         txe  <= 1'b1;
         tc   <= 1'b1;
         hold <= '0;
      end else begin
         if (dr_wr) begin
            hold <= dr_wdata;
            txe  <= 1'b0;
         end else if (take_ok) begin
            txe  <= 1'b1;
         end
         if (tc_set)      tc <= 1'b1;
         else if (tc_clr) tc <= 1'b0;
      end
   end

   p_write_clears_txe_r2: assert property (@(posedge clk) disable iff (!rst_n)
      dr_wr |=> !txe);

   p_take_sets_txe_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (shf_take && tx_valid && !dr_wr) |=> (txe && !tx_valid));

   p_tc_needs_stop_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(tc) |-> $past(shf_stop_done));

   p_tc_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (tc_clr && !shf_stop_done) |=> !tc);

endmodule

// File: rtl/usart_rx_flags.sv
module usart_rx_flags #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rx_path_on,
   input  logic              rx_valid,
   input  logic [DATA_W-1:0] rx_byte,
   input  logic              dr_rd,
   output logic              rxne,
   output logic              ore,
   output logic [DATA_W-1:0] rbuf
);

   logic rx_acc;
   logic lands;
   logic spills;

   assign rx_acc = rx_path_on & rx_valid;
   assign lands  = rx_acc & (~rxne | dr_rd);
   assign spills = rx_acc & rxne & ~dr_rd;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rxne <= 1'b0;
         ore  <= 1'b0;
         rbuf <= '0;
      end else begin
         if (lands) begin
            rbuf <= rx_byte;
            rxne <= 1'b1;
         end else if (dr_rd) begin
            rxne <= 1'b0;
         end
         if (spills)     ore <= 1'b1;
         else if (dr_rd) ore <= 1'b0;
      end
   end

   p_land_sets_full_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_acc && !rxne) |=> (rxne && rbuf == $past(rx_byte)));

   p_overrun_keeps_data_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_acc && rxne && !dr_rd) |=> (ore && $stable(rbuf)));

   p_read_clears_ore_r8: assert property (@(posedge clk) disable iff (!rst_n)
      dr_rd |=> !ore);

endmodule

// File: rtl/usart_stat_core.sv
module usart_stat_core
   import usart_core_pkg::*;
#(
   parameter int BUS_W   = 32,
   parameter int ADDR_W  = 4,
   parameter int DATA_W  = 8,
   parameter bit IRQ_REG = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [BUS_W-1:0]  bus_wdata,
   output logic [BUS_W-1:0]  bus_rdata,
   output logic [DATA_W-1:0] tx_data,
   output logic              tx_valid,
   input  logic              tx_take,
   input  logic              tx_stop_done,
   input  logic [DATA_W-1:0] rx_data,
   input  logic              rx_valid,
   output logic              dma_tx_req,
   output logic              dma_rx_req,
   output logic              irq
);

   localparam int IDX_W = ADDR_W - 2;

   if (BUS_W < 8 || DATA_W < 1 || DATA_W >= BUS_W || ADDR_W < 4) begin : g_bad_params
      $error("usart_stat_core: unsupported BUS_W/DATA_W/ADDR_W combination");
   end

   logic [IDX_W-1:0] idx;
   logic sel_stat, sel_data, sel_ctrl, sel_dmac;
   logic dr_wr, dr_rd, tc_clr;
   logic txe, tc, rxne, ore;
   logic [DATA_W-1:0] rbuf;
   logic [BUS_W-1:0] ctrl_word, dmac_word, stat_word;
   logic irq_now;
   cfg_t cfg;

   wire unused_bits = &{1'b0, bus_addr[1:0], bus_wdata[BUS_W-1:DATA_W]};

   assign idx      = bus_addr[ADDR_W-1:2];
   assign sel_stat = (idx == IDX_W'(REG_STAT));
   assign sel_data = (idx == IDX_W'(REG_DATA));
   assign sel_ctrl = (idx == IDX_W'(REG_CTRL));
   assign sel_dmac = (idx == IDX_W'(REG_DMAC));

   assign dr_wr  = bus_wr & sel_data & cfg.enable & cfg.tx_on;
   assign dr_rd  = bus_rd & sel_data;
   assign tc_clr = bus_wr & sel_stat & ~bus_wdata[ST_TC];

   usart_cfg_regs #(.BUS_W(BUS_W)) u_cfg (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_ctrl    (bus_wr & sel_ctrl),
      .wr_dmac    (bus_wr & sel_dmac),
      .ctrl_wdata (bus_wdata[CTRL_W-1:0]),
      .dmac_wdata (bus_wdata[DMAC_W-1:0]),
      .cfg        (cfg),
      .ctrl_word  (ctrl_word),
      .dmac_word  (dmac_word)
   );

   usart_tx_flags #(.DATA_W(DATA_W)) u_tx (
      .clk           (clk),
      .rst_n         (rst_n),
      .tx_path_on    (cfg.enable & cfg.tx_on),
      .dr_wr         (dr_wr),
      .dr_wdata      (bus_wdata[DATA_W-1:0]),
      .shf_take      (tx_take),
      .shf_stop_done (tx_stop_done),
      .tc_clr        (tc_clr),
      .txe           (txe),
      .tc            (tc),
      .hold          (tx_data),
      .tx_valid      (tx_valid)
   );

   usart_rx_flags #(.DATA_W(DATA_W)) u_rx (
      .clk        (clk),
      .rst_n      (rst_n),
      .rx_path_on (cfg.enable & cfg.rx_on),
      .rx_valid   (rx_valid),
      .rx_byte    (rx_data),
      .dr_rd      (dr_rd),
      .rxne       (rxne),
      .ore        (ore),
      .rbuf       (rbuf)
   );

   always_comb begin
      stat_word          = '0;
      stat_word[ST_TXE]  = txe;
      stat_word[ST_TC]   = tc;
      stat_word[ST_RXNE] = rxne;
      stat_word[ST_ORE]  = ore;
   end

   always_comb begin
      bus_rdata = '0;
      if (bus_rd) begin
         if (sel_stat)      bus_rdata = stat_word;
         else if (sel_data) bus_rdata = BUS_W'(rbuf);
         else if (sel_ctrl) bus_rdata = ctrl_word;
         else if (sel_dmac) bus_rdata = dmac_word;
      end
   end

   assign dma_tx_req = cfg.tx_dma & txe  & cfg.enable & cfg.tx_on;
   assign dma_rx_req = cfg.rx_dma & rxne & cfg.enable & cfg.rx_on;
   assign irq_now    = (tc & cfg.tc_ie) | (ore & cfg.err_ie);

   if (IRQ_REG) begin : g_irq_flop
      logic irq_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) irq_q <= 1'b0;
         else        irq_q <= irq_now;
      end
      assign irq = irq_q;
   end else begin : g_irq_comb
      assign irq = irq_now;
      p_irq_has_source_r9: assert property (@(posedge clk) disable iff (!rst_n)
         irq |-> (tc || ore));
   end

   p_ignored_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && sel_data && !(cfg.enable && cfg.tx_on)) |=> $stable(tx_data));

   p_dma_rx_drops_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (dma_rx_req && dr_rd && !rx_valid) |=> !dma_rx_req);

   p_disabled_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (!cfg.enable && !rxne) |=> !rxne);

endmodule

// File: tb/usart_stat_core_tb.sv
module usart_stat_core_tb;

   localparam int CLK_PERIOD = 10;
   localparam int WATCHDOG   = 20000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [3:0]  bus_addr = '0;
   logic        bus_wr = 1'b0;
   logic        bus_rd = 1'b0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [7:0]  tx_data;
   logic        tx_valid;
   logic        tx_take = 1'b0;
   logic        tx_stop_done = 1'b0;
   logic [7:0]  rx_data = '0;
   logic        rx_valid = 1'b0;
   logic        dma_tx_req, dma_rx_req, irq;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   // behavioural reference state
   bit         m_txe, m_tc, m_rxne, m_ore;
   logic [7:0] m_hold, m_rbuf;
   logic [3:0] m_ctrl;
   logic [2:0] m_dmac;
   logic [7:0] taken_q[$];

   always #(CLK_PERIOD/2) clk = ~clk;

   usart_stat_core u_dut (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
      .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .tx_data(tx_data), .tx_valid(tx_valid), .tx_take(tx_take),
      .tx_stop_done(tx_stop_done), .rx_data(rx_data), .rx_valid(rx_valid),
      .dma_tx_req(dma_tx_req), .dma_rx_req(dma_rx_req), .irq(irq)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", tag, act, exp, $time);
      end
   endtask

   function automatic logic [31:0] m_read(input logic [1:0] i);
      case (i)
         2'd0: return {24'd0, m_txe, m_tc, m_rxne, 1'b0, m_ore, 3'b000};
         2'd1: return {24'd0, m_rbuf};
         2'd2: return {28'd0, m_ctrl};
         default: return {29'd0, m_dmac};
      endcase
   endfunction

   task automatic model_reset();
      m_txe = 1; m_tc = 1; m_rxne = 0; m_ore = 0;
      m_hold = '0; m_rbuf = '0; m_ctrl = '0; m_dmac = '0;
   endtask

   task automatic compare_all();
      bit ue, te, re;
      ue = m_ctrl[0]; te = m_ctrl[1]; re = m_ctrl[2];
      chk("R2 R11 tx_valid", {31'd0, tx_valid}, {31'd0, ue && te && !m_txe});
      if (ue && te && !m_txe) chk("R2 tx_data", {24'd0, tx_data}, {24'd0, m_hold});
      chk("R10 dma_tx_req", {31'd0, dma_tx_req}, {31'd0, m_dmac[1] && m_txe && ue && te});
      chk("R10 dma_rx_req", {31'd0, dma_rx_req}, {31'd0, m_dmac[2] && m_rxne && ue && re});
      chk("R9 irq", {31'd0, irq}, {31'd0, (m_tc && m_ctrl[3]) || (m_ore && m_dmac[0])});
      chk("R1 R6 R7 readback", bus_rdata, bus_rd ? m_read(bus_addr[3:2]) : 32'd0);
   endtask

   task automatic model_step();
      bit ue, te, re, dr_wr, dr_rd, take, acc;
      bit n_txe, n_tc, n_rxne, n_ore;
      logic [1:0] i;
      i = bus_addr[3:2];
      ue = m_ctrl[0]; te = m_ctrl[1]; re = m_ctrl[2];
      dr_wr = bus_wr && i == 2'd1 && ue && te;
      dr_rd = bus_rd && i == 2'd1;
      take  = tx_take && ue && te && !m_txe;
      acc   = rx_valid && ue && re;
      n_txe = dr_wr ? 1'b0 : (take ? 1'b1 : m_txe);
      if (take && !dr_wr) taken_q.push_back(m_hold);
      if (tx_stop_done && m_txe && !dr_wr) n_tc = 1;
      else if (bus_wr && i == 2'd0 && !bus_wdata[6]) n_tc = 0;
      else n_tc = m_tc;
      n_rxne = m_rxne;
      if (acc && (!m_rxne || dr_rd)) begin
         n_rxne = 1; m_rbuf = rx_data;
      end else if (dr_rd) n_rxne = 0;
      if (acc && m_rxne && !dr_rd) n_ore = 1;
      else if (dr_rd) n_ore = 0;
      else n_ore = m_ore;
      if (dr_wr) m_hold = bus_wdata[7:0];
      if (bus_wr && i == 2'd2) m_ctrl = bus_wdata[3:0];
      if (bus_wr && i == 2'd3) m_dmac = bus_wdata[2:0];
      m_txe = n_txe; m_tc = n_tc; m_rxne = n_rxne; m_ore = n_ore;
   endtask

   task automatic tick();
      #1;
      compare_all();
      @(posedge clk);
      model_step();
      @(negedge clk);
      bus_wr = 0; bus_rd = 0; tx_take = 0; tx_stop_done = 0; rx_valid = 0;
   endtask

   task automatic wr_reg(input int i, input logic [31:0] d);
      bus_addr = 4'(i << 2); bus_wr = 1; bus_wdata = d;
      tick();
   endtask

   task automatic rd_expect(input int i, input logic [31:0] exp, input string tag);
      bus_addr = 4'(i << 2); bus_rd = 1;
      #1;
      chk(tag, bus_rdata, exp);
      tick();
   endtask

   task automatic pulse_take();      tx_take = 1;      tick(); endtask
   task automatic pulse_stop();      tx_stop_done = 1; tick(); endtask
   task automatic send_rx(input logic [7:0] b);
      rx_valid = 1; rx_data = b; tick();
   endtask

   initial begin
      repeat (WATCHDOG) @(posedge clk);
      if (!done) begin
         failures++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      model_reset();
      repeat (3) @(negedge clk);
      rst_n = 1;
      // R1 reset state
      rd_expect(0, 32'hC0, "R1 status");
      rd_expect(2, 32'h0, "R1 ctrl");
      rd_expect(3, 32'h0, "R1 dmac");
      // R11 disabled port ignores traffic
      send_rx(8'h55);
      rd_expect(0, 32'hC0, "R11 rx ignored");
      wr_reg(1, 32'hAA);
      rd_expect(0, 32'hC0, "R2 write ignored");
      rd_expect(1, 32'h00, "R11 no byte stored");
      // R5 and R9
      wr_reg(2, 32'hF);
      chk("R9 tc irq", {31'd0, irq}, 32'd1);
      wr_reg(0, 32'hFFFF_FFFF);
      rd_expect(0, 32'hC0, "R5 write one keeps tc");
      wr_reg(0, 32'h0);
      rd_expect(0, 32'h80, "R5 write zero clears tc");
      chk("R9 irq off", {31'd0, irq}, 32'd0);
      // R2 R3 R4 basic transmit
      wr_reg(1, 32'h3C);
      rd_expect(0, 32'h00, "R2 txe cleared");
      chk("R2 offer", {23'd0, tx_valid, tx_data}, {23'd0, 1'b1, 8'h3C});
      pulse_take();
      rd_expect(0, 32'h80, "R3 txe set");
      pulse_stop();
      rd_expect(0, 32'hC0, "R4 tc set");
      // R4 pending byte blocks tc
      wr_reg(0, 32'h0);
      wr_reg(1, 32'h11);
      pulse_take();
      wr_reg(1, 32'h22);
      pulse_stop();
      rd_expect(0, 32'h00, "R4 pending blocks tc");
      pulse_take();
      pulse_stop();
      rd_expect(0, 32'hC0, "R4 tc after drain");
      wr_reg(0, 32'h0);
      bus_addr = 4'h4; bus_wr = 1; bus_wdata = 32'h33; tx_stop_done = 1;
      tick();
      rd_expect(0, 32'h00, "R4 same-cycle write blocks tc");
      pulse_take();
      pulse_stop();
      rd_expect(0, 32'hC0, "R4 tc again");
      chk("R3 bytes in order", taken_q.size(), 4);
      chk("R3 first byte", {24'd0, taken_q[0]}, 32'h3C);
      // R6 R7 R8 receive
      send_rx(8'h5A);
      rd_expect(0, 32'hE0, "R6 rxne set");
      send_rx(8'h77);
      rd_expect(0, 32'hE8, "R7 overrun set");
      rd_expect(1, 32'h5A, "R7 first byte kept");
      rd_expect(0, 32'hC0, "R8 overrun cleared");
      // R9 error interrupt
      wr_reg(3, 32'h1);
      wr_reg(0, 32'h0);
      send_rx(8'h01);
      send_rx(8'h02);
      chk("R9 overrun irq", {31'd0, irq}, 32'd1);
      rd_expect(1, 32'h01, "R8 read returns kept byte");
      chk("R9 irq after read", {31'd0, irq}, 32'd0);
      // R10 DMA requests
      wr_reg(3, 32'h7);
      chk("R10 tx req", {31'd0, dma_tx_req}, 32'd1);
      chk("R10 rx req idle", {31'd0, dma_rx_req}, 32'd0);
      send_rx(8'h44);
      chk("R10 rx req", {31'd0, dma_rx_req}, 32'd1);
      rd_expect(1, 32'h44, "R6 dma read");
      chk("R10 rx req drop", {31'd0, dma_rx_req}, 32'd0);
      wr_reg(1, 32'h66);
      chk("R10 tx req drop", {31'd0, dma_tx_req}, 32'd0);
      pulse_take();
      // R6 read racing a new byte
      send_rx(8'h81);
      bus_addr = 4'h4; bus_rd = 1; rx_valid = 1; rx_data = 8'h92;
      #1;
      chk("R6 race read old", bus_rdata, 32'h81);
      tick();
      rd_expect(0, 32'hA0, "R7 race no overrun");
      rd_expect(1, 32'h92, "R6 race new byte");
      // R10 R2 transmitter off
      wr_reg(2, 32'h5);
      chk("R10 tx off no req", {31'd0, dma_tx_req}, 32'd0);
      wr_reg(1, 32'h10);
      rd_expect(0, 32'h80, "R2 tx off write ignored");
      // R11 port off
      wr_reg(2, 32'h0);
      send_rx(8'h03);
      rd_expect(0, 32'h80, "R11 rx ignored again");
      repeat (4) tick();
      done = 1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule